// File: doc/BRIEF.md
# Converter Serial Configuration and Result Port

This block is the digital front end of a small data-acquisition converter. A host talks to it over a four-wire synchronous full-duplex serial link: an active-low chip select, a serial clock, a data input and a data output. Each chip-select cycle carries two things at once. The host shifts in an 8-bit configuration word for the next conversion. At the same time the block shifts out the result of the conversion that the previous word asked for, so every result arrives one chip-select cycle after its request. The configuration word picks the analog channel (or channel pair and its polarity), the output coding, the bit order and the output word length.

When chip select rises after a complete word, the block drives the channel address to the multiplexer and pulses a start strobe to the converter. It then waits for the 10-bit sample on a valid/ready input port. The sample port uses back-pressure in one direction only. `smp_ready` is high only while a requested conversion is outstanding, and any `smp_valid` seen while `smp_ready` is low is ignored. A sample is accepted on the first clock where both are high, and `smp_ready` falls on the next clock. The accepted sample is held together with its request's format settings until the next transfer starts. If a full word arrives while a conversion is still outstanding, that word is discarded.

The serial pins are oversampled on the system clock through `SYNC_STAGES` synchronizer flops. Outputs follow a pin edge within `SYNC_STAGES + 2` clocks. Each serial clock phase and each chip-select phase must therefore last at least `SYNC_STAGES + 3` system clocks.

Top module: `adc_serial_cfg_if`

## Requirements
- R1: After reset, `dout_oe`, `dout`, `conv_start` and `smp_ready` are 0, `mux_addr` is 0, and the held result is zero.
- R2: The configuration word is taken from `din` on the first eight rising `sclk` edges after `cs_n` falls. In arrival order the bits are: `mux_addr[3]`, `mux_addr[2]`, `mux_addr[1]`, `mux_addr[0]`, the coding bit (1 = straight binary), the order bit (1 = MSB first), the length bit 1 and the length bit 0.
- R3: `din` bits after the eighth rising `sclk` edge of a transfer have no effect on the configuration.
- R4: When `cs_n` rises after a complete word while no conversion is outstanding, `conv_start` is high for exactly one clock. `mux_addr` takes the word's address in that same clock, and `smp_ready` is high from that clock on.
- R5: When `cs_n` rises after fewer than eight bits, no conversion is started, `mux_addr` is unchanged, and the next transfer repeats the previously held result.
- R6: `smp_valid` is ignored while `smp_ready` is low. A sample is accepted on the clock where both are high, and `smp_ready` is low on the following clock.
- R7: A transfer shifts out the last accepted sample, formatted with the settings of the word that requested it. Before any sample has been accepted, the frame is all zeros.
- R8: The first output bit appears on `dout` after `cs_n` falls, and each falling `sclk` edge advances to the next bit. The host samples on the rising edge.
- R9: With order bit 1 the data bits go out from bit 9 down to bit 0. With order bit 0 they go out from bit 0 up to bit 9.
- R10: With coding bit 1 the sample is sent unchanged. With coding bit 0 its bit 9 is inverted, which turns offset binary into two's complement.
- R11: The length code selects the frame length: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. An 8-bit frame carries the first eight data bits of the chosen order. Positions after the ten data bits, and all bits after the frame, are 0.
- R12: While the transfer is idle (`cs_n` high), `dout_oe` and `dout` are 0. During a transfer, `dout_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial result data out |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| mux_addr | output | 4 | Channel / pair / polarity select to the analog multiplexer |
| conv_start | output | 1 | One-clock conversion start strobe |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Block waits for a sample |
| smp_data | input | 10 | Converter sample value, offset binary |

## Verification
The bench runs seven back-to-back transfers. Each one changes the order, coding and length settings, so a design that sent the current result instead of the previous one, or formatted it with the wrong word's settings, shows bit mismatches at once. One transfer ends after five bits: a design that started anyway would raise an unexpected strobe and move the address, and one that cleared the held result would output zeros on the replay. Transfers with extra clocks drive junk after the eighth bit and run past sixteen bits. This catches a design that kept shifting configuration bits or failed to pad with zeros. A `smp_valid` pulse before any request catches a design that accepts samples without `smp_ready`.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  localparam int CFG_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int RES_W   = 10;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(CFG_W + 1);

  // field order matches arrival order: first bit lands in the MSB
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              straight;
    logic              msb_first;
    logic [1:0]        len_code;
  } cfg_t;

  typedef enum logic {CV_IDLE, CV_WAIT} cv_state_t;

  function automatic int unsigned frame_len(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/adc_cfg_capture.sv
module adc_cfg_capture
  import adc_sp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic bit_strobe,
  input  logic din_bit,
  output cfg_t cfg,
  output logic full
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CFG_W);

  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (frame_start) begin
      cnt <= '0;
    end else if (bit_strobe && cnt < CNT_MAX) begin
      sh  <= {sh[CFG_W-2:0], din_bit};
      cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_MAX);
  assign cfg  = cfg_t'(sh);

  p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
  p_word_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !frame_start) |=> $stable(sh));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_sp_pkg::*;
(
  input  logic [RES_W-1:0]   value,
  input  cfg_t               cfg,
  output logic [FRAME_W-1:0] frame
);
  logic [RES_W-1:0]   coded, rev, ordered;
  logic [FRAME_W-1:0] placed, keep;

  assign coded = cfg.straight ? value : (value ^ {1'b1, {(RES_W-1){1'b0}}});

  for (genvar g = 0; g < RES_W; g++) begin : g_rev
    assign rev[g] = coded[RES_W-1-g];
  end

  assign ordered = cfg.msb_first ? coded : rev;
  assign placed  = {ordered, {(FRAME_W-RES_W){1'b0}}};

  for (genvar g = 0; g < FRAME_W; g++) begin : g_keep
    assign keep[FRAME_W-1-g] = (frame_len(cfg.len_code) > g);
  end

  assign frame = placed & keep;
endmodule

// File: rtl/adc_dout_shift.sv
module adc_dout_shift
  import adc_sp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               adv,
  input  logic               stop,
  output logic               dout,
  output logic               dout_oe
);
  logic [FRAME_W-1:0] sh;
  logic               oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      oe <= 1'b0;
    end else if (load) begin
      sh <= frame_in;
      oe <= 1'b1;
    end else if (stop) begin
      sh <= '0;
      oe <= 1'b0;
    end else if (oe && adv) begin
      sh <= {sh[FRAME_W-2:0], 1'b0};
    end
  end

  assign dout    = oe & sh[FRAME_W-1];
  assign dout_oe = oe;

  p_quiet_after_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> (!dout_oe && !dout));
endmodule

// File: rtl/adc_serial_cfg_if.sv
module adc_serial_cfg_if
  import adc_sp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              conv_start,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [RES_W-1:0]  smp_data
);
  logic [2:0] pin_lvl;
  logic       cs_prev, sclk_prev, xfer_on;
  logic       cs_fall, cs_rise, sclk_rise, sclk_fall;
  cfg_t       cfg, req_cfg, res_cfg;
  logic       cfg_full;
  logic [RES_W-1:0]   res_val;
  logic [FRAME_W-1:0] frame;
  cv_state_t          state;

  adc_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({cs_n, sclk, din}), .lvl(pin_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      xfer_on   <= 1'b0;
    end else begin
      cs_prev   <= pin_lvl[2];
      sclk_prev <= pin_lvl[1];
      if (cs_fall)      xfer_on <= 1'b1;
      else if (cs_rise) xfer_on <= 1'b0;
    end
  end

  assign cs_fall   = cs_prev & ~pin_lvl[2];
  assign cs_rise   = ~cs_prev & pin_lvl[2];
  assign sclk_rise = ~sclk_prev & pin_lvl[1];
  assign sclk_fall = sclk_prev & ~pin_lvl[1];

  adc_cfg_capture u_cap (
    .clk(clk), .rst_n(rst_n), .frame_start(cs_fall),
    .bit_strobe(xfer_on & sclk_rise), .din_bit(pin_lvl[0]),
    .cfg(cfg), .full(cfg_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CV_IDLE;
      conv_start <= 1'b0;
      mux_addr   <= '0;
      req_cfg    <= '0;
      res_cfg    <= '0;
      res_val    <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        CV_IDLE: if (cs_rise && xfer_on && cfg_full) begin
          conv_start <= 1'b1;
          mux_addr   <= cfg.addr;
          req_cfg    <= cfg;
          state      <= CV_WAIT;
        end
        CV_WAIT: if (smp_valid) begin
          res_val <= smp_data;
          res_cfg <= req_cfg;
          state   <= CV_IDLE;
        end
        default: state <= CV_IDLE;
      endcase
    end
  end

  assign smp_ready = (state == CV_WAIT);

  adc_result_fmt u_fmt (.value(res_val), .cfg(res_cfg), .frame(frame));

  adc_dout_shift u_out (
    .clk(clk), .rst_n(rst_n), .load(cs_fall), .frame_in(frame),
    .adv(xfer_on & sclk_fall), .stop(cs_rise), .dout(dout), .dout_oe(dout_oe));

  p_start_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_start_with_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> smp_ready);
  p_addr_only_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_addr != $past(mux_addr)) |-> conv_start);
  p_start_needs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(cfg_full && cs_rise));
  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

// File: tb/adc_serial_cfg_if_tb.sv
module adc_serial_cfg_if_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cs_n, sclk, din, dout, dout_oe, conv_start;
  logic       smp_valid, smp_ready;
  logic [3:0] mux_addr;
  logic [9:0] smp_data;

  adc_serial_cfg_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .mux_addr(mux_addr),
    .conv_start(conv_start), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data));

  int n_chk = 0, n_bad = 0, starts = 0;
  logic       chk_idle = 1'b0;
  logic [9:0] m_val = '0, next_sample = '0;
  logic [7:0] m_cfg = '0;
  logic [3:0] exp_addr = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference: bit i of the frame for value v and word c
  function automatic logic exp_bit(input logic [9:0] v, input logic [7:0] c, input int i);
    int len;
    logic [9:0] x;
    case (c[1:0])
      2'd0: len = 8;
      2'd1: len = 10;
      2'd2: len = 12;
      default: len = 16;
    endcase
    if (i >= len || i >= 10) return 1'b0;
    x = c[3] ? v : {~v[9], v[8:0]};
    return c[2] ? x[9-i] : x[i];
  endfunction

  // R12: idle pins quiet, compared every clock
  always @(negedge clk) begin
    if (rst_n && chk_idle) begin
      check("R12 idle oe", {31'b0, dout_oe}, 0);
      check("R12 idle dout", {31'b0, dout}, 0);
    end
  end

  // converter model
  initial begin
    smp_valid = 1'b0;
    smp_data  = '0;
    wait (rst_n === 1'b1);
    wclk(2);
    smp_valid = 1'b1;
    smp_data  = 10'h3FF;
    for (int k = 0; k < 4; k++) begin
      wclk(1);
      check("R6 no ready without request", {31'b0, smp_ready}, 0);
    end
    smp_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && conv_start) begin
        starts++;
        check("R2/R4 addr", {28'b0, mux_addr}, {28'b0, exp_addr});
        check("R4 ready with start", {31'b0, smp_ready}, 1);
        wclk(3);
        check("R6 ready held", {31'b0, smp_ready}, 1);
        smp_valid = 1'b1;
        smp_data  = next_sample;
        wclk(1);
        smp_valid = 1'b0;
        check("R6 ready drop", {31'b0, smp_ready}, 0);
      end
    end
  end

  task automatic xfer(input logic [7:0] w, input int n, input logic [9:0] smp,
                      input logic [15:0] junk);
    int s0;
    chk_idle = 1'b0;
    next_sample = smp;
    if (n >= 8) exp_addr = w[7:4];
    cs_n = 1'b0;
    wclk(HALF);
    check("R12 oe active", {31'b0, dout_oe}, 1);
    for (int i = 0; i < n; i++) begin
      din = (i < 8) ? w[7-i] : junk[i-8];
      wclk(HALF);
      check($sformatf("R7/R8/R9/R10/R11 bit %0d", i), {31'b0, dout},
            {31'b0, exp_bit(m_val, m_cfg, i)});
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    s0 = starts;
    cs_n = 1'b1;
    wclk(3 * HALF);
    chk_idle = 1'b1;
    if (n >= 8) begin
      check("R4 one start", starts, s0 + 1);
      m_val = smp;
      m_cfg = w;
    end else begin
      check("R5 no start", starts, s0);
      check("R5 addr kept", {28'b0, mux_addr}, {28'b0, exp_addr});
    end
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
    wclk(4);
    check("R1 oe", {31'b0, dout_oe}, 0);
    check("R1 dout", {31'b0, dout}, 0);
    check("R1 start", {31'b0, conv_start}, 0);
    check("R1 ready", {31'b0, smp_ready}, 0);
    check("R1 addr", {28'b0, mux_addr}, 0);
    rst_n = 1'b1;
    wclk(12);
    chk_idle = 1'b1;
    xfer(8'hBD, 8,  10'h2C5, 16'h0000); // R7 zeros first; straight, MSB first, 10 bits
    xfer(8'h60, 12, 10'h13A, 16'hFFFF); // R3 junk; sends 2C5
    xfer(8'hF6, 16, 10'h001, 16'h00FF); // R10/R9 sends 13A bipolar LSB first 8 bits
    xfer(8'h2B, 5,  10'h2AA, 16'h0000); // R5 short word
    xfer(8'h0F, 18, 10'h155, 16'hFFFF); // R5 replay of 001 as 12-bit, R11 tail
    xfer(8'h9C, 16, 10'h3FF, 16'hA5A5); // sends 155 over 16 bits
    xfer(8'h00, 10, 10'h000, 16'h0000); // sends 3FF as 8 bits
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wclk(150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule